// File: doc/BRIEF.md
# Transceiver rate reconfiguration sequencer

This block carries out one rate change on one transceiver channel. An arbiter gives it a start strobe, a channel index and a rate mode. The sequencer first waits until the reconfiguration controller is idle and the reset controller reports both directions ready. It then drives the target channel number and the image selection, and pulses a stream-start strobe. Next it watches the controller's busy line go high and then low again.

After reconfiguration it pulses the digital reset of the affected channel for a fixed number of cycles. It then waits for the link to come up and signals completion. While a request is in progress an acknowledge/busy level stays high. Its fall tells the arbiter that a new request may be issued.

Two of the waits can stall: the wait for the controller to start, and the wait for the link to come up. Each has a cycle limit. When a limit runs out, the sequencer raises an error pulse instead of completion and returns to idle.

Top module: `xcvr_rate_seq`

## Requirements
- R1: After reset, tgt_chan_o is 0 and ack_o, stream_go_o, image_sel_o, pcs_rst_o, done_o and error_o are all low.
- R2: A start strobe is taken only while the sequencer is idle. A strobe seen while ack_o is high has no effect on tgt_chan_o, image_sel_o or the outcome of the request in progress.
- R3: ack_o is high from the cycle after an accepted strobe. It falls in the same cycle as the done_o or error_o pulse of that request.
- R4: The sequencer does not advance towards streaming while cfg_busy_i is high or either tx_ready_i or rx_ready_i is low.
- R5: tgt_chan_o takes the requested channel one cycle before stream_go_o. stream_go_o is a single-cycle pulse, given once per request.
- R6: image_sel_o takes the requested mode (0 selects the 1G image, 1 selects the 10G image) in the same cycle as tgt_chan_o. It stays stable until the next request sets it.
- R7: Completion requires cfg_busy_i to be seen high and then low. If cfg_busy_i is not high by cycle BUSY_TMO+1, where the stream_go_o cycle counts as cycle 1, then error_o pulses.
- R8: After cfg_busy_i falls, pcs_rst_o has only the bit of the target channel set. That bit stays high for exactly RST_HOLD cycles.
- R9: link_up_i is waited for only after pcs_rst_o has cleared. Counting the first cycle with pcs_rst_o low as cycle 1, a link_up_i that is high in cycle LINK_TMO+2 or earlier leads to completion. Otherwise error_o pulses.
- R10: done_o and error_o are single-cycle pulses and never high together. After either one, a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start_i | input | 1 | Request strobe from the arbiter |
| req_chan_i | input | CH_W | Requested channel index |
| req_mode_i | input | 1 | Requested rate: 0 = 1G, 1 = 10G |
| cfg_busy_i | input | 1 | Busy level from the reconfiguration controller |
| tx_ready_i | input | 1 | Transmit side ready from the reset controller |
| rx_ready_i | input | 1 | Receive side ready from the reset controller |
| link_up_i | input | 1 | Link ready indication |
| tgt_chan_o | output | CH_W | Channel number for the reconfiguration controller |
| stream_go_o | output | 1 | One-cycle strobe that starts image streaming |
| image_sel_o | output | 1 | Settings image select: 0 = 1G, 1 = 10G |
| pcs_rst_o | output | NUM_CH | Per-channel digital reset |
| ack_o | output | 1 | Acknowledge/busy level to the arbiter |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | One-cycle timeout pulse |

## Verification
The two functions that can coincide are the arrival of the awaited event and the expiry of its timeout. This applies both to cfg_busy_i going high and to link_up_i, since the event and the expiry are decided on the same clock edge. The bench's controller and link model place the event exactly in the last allowed cycle, and then one cycle later. It expects completion in the first case and an error pulse in the second. The scoreboard judges each outcome by whether done_o or error_o fires and by the channel and image reported with it.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_WAIT_READY,
    S_SET_CHANNEL,
    S_START_STREAM,
    S_WAIT_BUSY_HIGH,
    S_WAIT_BUSY_LOW,
    S_RESET_ASSERT,
    S_RESET_RELEASE,
    S_WAIT_LINK,
    S_DONE
  } seq_state_t;
endpackage

// File: rtl/rseq_timer.sv
module rseq_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (en && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

  // the counter holds at zero and never wraps (R8 hold, R7/R9 limits)
  assert_floor_R8: assert property (@(posedge clk) disable iff (rst)
    (en && !load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/rseq_chan_dec.sv
module rseq_chan_dec #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [W-1:0] idx,
  output logic [N-1:0] hot
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign hot[i] = (idx == W'(i));
  end
endmodule

// File: rtl/xcvr_rate_seq.sv
module xcvr_rate_seq
  import rseq_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int RST_HOLD = 4,
  parameter int BUSY_TMO = 16,
  parameter int LINK_TMO = 20,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start_i,
  input  logic [CH_W-1:0]   req_chan_i,
  input  logic              req_mode_i,
  input  logic              cfg_busy_i,
  input  logic              tx_ready_i,
  input  logic              rx_ready_i,
  input  logic              link_up_i,
  output logic [CH_W-1:0]   tgt_chan_o,
  output logic              stream_go_o,
  output logic              image_sel_o,
  output logic [NUM_CH-1:0] pcs_rst_o,
  output logic              ack_o,
  output logic              done_o,
  output logic              error_o
);
  localparam int TMAX1 = (BUSY_TMO > LINK_TMO) ? BUSY_TMO : LINK_TMO;
  localparam int TMAX  = (TMAX1 > RST_HOLD) ? TMAX1 : RST_HOLD;
  localparam int CNT_W = $clog2(TMAX + 1);

  seq_state_t        state_q;
  logic [CH_W-1:0]   chan_q;
  logic              mode_q;
  logic [NUM_CH-1:0] chan_hot;

  logic             tmo_load, tmo_en, tmo_zero;
  logic [CNT_W-1:0] tmo_val;
  logic             hold_load, hold_en, hold_zero;
  logic             sys_ready;

  assign sys_ready = !cfg_busy_i && tx_ready_i && rx_ready_i;

  // timeout counter serves both the busy-rise wait and the link wait
  assign tmo_load = (state_q == S_START_STREAM) || (state_q == S_RESET_RELEASE);
  assign tmo_val  = (state_q == S_START_STREAM) ? CNT_W'(BUSY_TMO) : CNT_W'(LINK_TMO);
  assign tmo_en   = (state_q == S_WAIT_BUSY_HIGH) || (state_q == S_WAIT_LINK);

  assign hold_load = (state_q == S_WAIT_BUSY_LOW) && !cfg_busy_i;
  assign hold_en   = (state_q == S_RESET_ASSERT);

  rseq_timer #(.W(CNT_W)) u_tmo (
    .clk(clk), .rst(rst), .load(tmo_load), .load_val(tmo_val),
    .en(tmo_en), .zero(tmo_zero)
  );

  rseq_timer #(.W(CNT_W)) u_hold (
    .clk(clk), .rst(rst), .load(hold_load), .load_val(CNT_W'(RST_HOLD - 1)),
    .en(hold_en), .zero(hold_zero)
  );

  rseq_chan_dec #(.N(NUM_CH), .W(CH_W)) u_dec (
    .idx(tgt_chan_o), .hot(chan_hot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      chan_q      <= '0;
      mode_q      <= 1'b0;
      tgt_chan_o  <= '0;
      image_sel_o <= 1'b0;
      stream_go_o <= 1'b0;
      pcs_rst_o   <= '0;
      ack_o       <= 1'b0;
      done_o      <= 1'b0;
      error_o     <= 1'b0;
    end else begin
      stream_go_o <= 1'b0;
      done_o      <= 1'b0;
      error_o     <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_start_i) begin
            chan_q  <= req_chan_i;
            mode_q  <= req_mode_i;
            ack_o   <= 1'b1;
            state_q <= S_WAIT_READY;
          end
        end
        S_WAIT_READY: begin
          if (sys_ready) state_q <= S_SET_CHANNEL;
        end
        S_SET_CHANNEL: begin
          tgt_chan_o  <= chan_q;
          image_sel_o <= mode_q;
          state_q     <= S_START_STREAM;
        end
        S_START_STREAM: begin
          stream_go_o <= 1'b1;
          state_q     <= S_WAIT_BUSY_HIGH;
        end
        S_WAIT_BUSY_HIGH: begin
          if (cfg_busy_i) begin
            state_q <= S_WAIT_BUSY_LOW;
          end else if (tmo_zero) begin
            error_o <= 1'b1;
            ack_o   <= 1'b0;
            state_q <= S_IDLE;
          end
        end
        S_WAIT_BUSY_LOW: begin
          if (!cfg_busy_i) begin
            pcs_rst_o <= chan_hot;
            state_q   <= S_RESET_ASSERT;
          end
        end
        S_RESET_ASSERT: begin
          if (hold_zero) begin
            pcs_rst_o <= '0;
            state_q   <= S_RESET_RELEASE;
          end
        end
        S_RESET_RELEASE: begin
          state_q <= S_WAIT_LINK;
        end
        S_WAIT_LINK: begin
          if (link_up_i) begin
            done_o  <= 1'b1;
            ack_o   <= 1'b0;
            state_q <= S_DONE;
          end else if (tmo_zero) begin
            error_o <= 1'b1;
            ack_o   <= 1'b0;
            state_q <= S_IDLE;
          end
        end
        S_DONE: begin
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    stream_go_o |=> !stream_go_o);

  assert_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_SET_CHANNEL) |=> ($stable(image_sel_o) && $stable(tgt_chan_o)));

  assert_busyfall_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(|pcs_rst_o) |-> $past(!cfg_busy_i));

  assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pcs_rst_o));

  assert_link_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(link_up_i));

  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(done_o && error_o));

  assert_ackfall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> (done_o || error_o));
endmodule

// File: tb/xcvr_rate_seq_tb.sv
module xcvr_rate_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH   = 4;
  localparam int RST_HOLD = 4;
  localparam int BUSY_TMO = 16;
  localparam int LINK_TMO = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_start_i = 1'b0;
  logic [1:0] req_chan_i = '0;
  logic req_mode_i = 1'b0;
  logic cfg_busy_i = 1'b0;
  logic tx_ready_i = 1'b1;
  logic rx_ready_i = 1'b1;
  logic link_up_i = 1'b0;
  logic [1:0] tgt_chan_o;
  logic stream_go_o, image_sel_o, ack_o, done_o, error_o;
  logic [NUM_CH-1:0] pcs_rst_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_rate_seq #(.NUM_CH(NUM_CH), .RST_HOLD(RST_HOLD),
                  .BUSY_TMO(BUSY_TMO), .LINK_TMO(LINK_TMO)) u_dut (
    .clk(clk), .rst(rst), .req_start_i(req_start_i), .req_chan_i(req_chan_i),
    .req_mode_i(req_mode_i), .cfg_busy_i(cfg_busy_i), .tx_ready_i(tx_ready_i),
    .rx_ready_i(rx_ready_i), .link_up_i(link_up_i), .tgt_chan_o(tgt_chan_o),
    .stream_go_o(stream_go_o), .image_sel_o(image_sel_o), .pcs_rst_o(pcs_rst_o),
    .ack_o(ack_o), .done_o(done_o), .error_o(error_o)
  );

  typedef struct { int ch; bit md; bit ok; } exp_t;
  exp_t exp_q[$];

  int n_checks = 0;
  int n_fail   = 0;
  int stream_cnt = 0;
  bit ended = 0;

  task automatic check(bit cond, string req, int act, int exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pulses, reset width, scoreboard compare
  bit prev_stream = 0;
  int rst_w = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (stream_go_o) begin
        stream_cnt++;
        check(!prev_stream, "R5 stream pulse width", 2, 1);
        if (exp_q.size() > 0) begin
          check(tgt_chan_o == exp_q[0].ch[1:0], "R5 chan at stream", int'(tgt_chan_o), exp_q[0].ch);
          check(image_sel_o == exp_q[0].md, "R6 image at stream", int'(image_sel_o), int'(exp_q[0].md));
        end
      end
      prev_stream = stream_go_o;
      if (pcs_rst_o != '0) begin
        rst_w++;
        check(pcs_rst_o == (4'b1 << tgt_chan_o), "R8 reset bit", int'(pcs_rst_o), 1 << tgt_chan_o);
      end else if (rst_w != 0) begin
        check(rst_w == RST_HOLD, "R8 reset width", rst_w, RST_HOLD);
        rst_w = 0;
      end
      if (done_o || error_o) begin
        check(!(done_o && error_o), "R10 exclusive", 1, 0);
        check(!ack_o, "R3 ack low at end", int'(ack_o), 0);
        if (exp_q.size() == 0) begin
          check(0, "R10 unexpected end pulse", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(done_o == e.ok, "R7 R9 outcome done", int'(done_o), int'(e.ok));
          check(tgt_chan_o == e.ch[1:0], "R2 chan at end", int'(tgt_chan_o), e.ch);
          check(image_sel_o == e.md, "R6 image at end", int'(image_sel_o), int'(e.md));
        end
      end
    end
  end

  task automatic issue(int ch, bit md, bit ok);
    exp_t e;
    e.ch = ch; e.md = md; e.ok = ok;
    exp_q.push_back(e);
    @(negedge clk);
    req_start_i = 1'b1; req_chan_i = ch[1:0]; req_mode_i = md;
    @(negedge clk);
    req_start_i = 1'b0;
    check(ack_o, "R3 ack after start", int'(ack_o), 1);
  endtask

  // controller and link model
  task automatic serve(int bdly, int blen, int ldly, bit poke);
    int n = 0;
    while (!stream_go_o && n < 200) begin @(negedge clk); n++; end
    check(stream_go_o, "R5 stream seen", int'(stream_go_o), 1);
    repeat (bdly - 1) @(negedge clk);
    cfg_busy_i = 1'b1;
    if (poke) begin
      req_start_i = 1'b1; req_chan_i = 2'd3; req_mode_i = ~req_mode_i;
    end
    @(negedge clk);
    req_start_i = 1'b0;
    repeat (blen - 1) @(negedge clk);
    cfg_busy_i = 1'b0;
    if (!ack_o) return;
    n = 0;
    while (pcs_rst_o == '0 && n < 200) begin @(negedge clk); n++; end
    while (pcs_rst_o != '0 && n < 400) begin @(negedge clk); n++; end
    repeat (ldly - 1) @(negedge clk);
    link_up_i = 1'b1;
    n = 0;
    while (ack_o && n < 200) begin @(negedge clk); n++; end
    link_up_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int sc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(tgt_chan_o == 0 && !ack_o && !stream_go_o && !image_sel_o &&
          pcs_rst_o == 0 && !done_o && !error_o, "R1 reset state",
          int'({tgt_chan_o, ack_o, stream_go_o, image_sel_o, pcs_rst_o, done_o, error_o}), 0);

    issue(1, 0, 1); serve(3, 5, 4, 0);
    issue(2, 1, 1); serve(1, 2, 1, 0);

    // R4 gating on readiness and controller busy
    tx_ready_i = 1'b0; cfg_busy_i = 1'b1;
    sc = stream_cnt;
    issue(3, 1, 1);
    repeat (8) @(negedge clk);
    check(stream_cnt == sc && tgt_chan_o == 2'd2, "R4 held by not-ready", stream_cnt - sc, 0);
    tx_ready_i = 1'b1;
    repeat (6) @(negedge clk);
    check(stream_cnt == sc && tgt_chan_o == 2'd2, "R4 held by busy", stream_cnt - sc, 0);
    rx_ready_i = 1'b0; cfg_busy_i = 1'b0;
    repeat (6) @(negedge clk);
    check(stream_cnt == sc, "R4 held by rx not ready", stream_cnt - sc, 0);
    rx_ready_i = 1'b1;
    serve(2, 3, 2, 0);

    // R2 start strobe during a request is ignored
    issue(0, 0, 1); serve(2, 4, 3, 1);
    check(tgt_chan_o == 0 && image_sel_o == 0, "R2 poke ignored", int'(tgt_chan_o), 0);

    // R7 busy-rise boundary and timeout
    issue(1, 1, 1); serve(BUSY_TMO + 1, 2, 2, 0);
    issue(2, 0, 0); serve(BUSY_TMO + 2, 2, 2, 0);
    check(!ack_o && pcs_rst_o == 0, "R7 no reset after timeout", int'(pcs_rst_o), 0);

    // R9 link boundary and timeout
    issue(3, 0, 1); serve(2, 2, LINK_TMO + 2, 0);
    issue(1, 1, 0); serve(2, 2, LINK_TMO + 3, 0);

    // R10 recovery after error
    issue(2, 1, 1); serve(2, 3, 5, 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 all requests ended", exp_q.size(), 0);
    check(stream_cnt == 9, "R5 one stream per request", stream_cnt, 9);
    finish_run();
  end
endmodule